// File: doc/BRIEF.md
# Capped-Regime Tapered-Precision Decoder

This block turns one N-bit tapered-precision codeword into its parts in a single combinational pass, with no clock and no state. The header holds a sign bit, a direction bit and a 3-bit run pattern. The run pattern and the direction bit together set a run length between 0 and 7. That many characteristic bits follow the header, and every remaining bit is mantissa. The run is read from a fixed 3-bit field instead of being counted from a leading-bit run. The logic in front of the exponent therefore looks at no more than seven bits, and the decode depth stays about the same from N = 8 up to N = 64.

The outputs are the sign, a 9-bit signed exponent, and the mantissa left-justified into a fixed field of N-5 bits. The block also raises two flags: one for the zero codeword and one for the reserved Not-a-Real codeword. When the `EMIT_LOG` parameter is set, the block also produces the value in logarithmic mode as a signed fixed-point number. A floating-point or log-domain datapath places this decoder in front of its arithmetic. The datapath adds its own pipeline registers around it.

Top module: `tapered_decoder`

## Requirements
- R1: `sign_o` equals the most significant bit of `code_i`. Below the sign bit come the direction bit (bit N-2), the run pattern P (bits N-3 down to N-5), the characteristic field, and then the mantissa.
- R2: The run length r equals P when the direction bit is 1 and 7-P when it is 0. The characteristic field is the r bits directly below the run pattern, read as an unsigned integer C.
- R3: If the direction bit is 1, the characteristic is c = 2^r - 1 + C, which lies in 0..254. For sign 0, `exp_o` equals c.
- R4: If the direction bit is 0, the characteristic is c = C + 1 - 2^(r+1), which lies in -255..-1. For sign 0, `exp_o` equals c.
- R5: For sign 1, `exp_o` equals -(c+1). For any codeword other than zero or Not-a-Real, `exp_o` is negative exactly when the sign bit equals the direction bit.
- R6: `mant_o` (N-5 bits) holds the mantissa bits that follow the characteristic, starting at its MSB. The lowest r bits are zero.
- R7: The all-zero codeword sets `zero_o`, clears `nar_o`, and drives `exp_o`, `mant_o` and `log_o` to 0.
- R8: The codeword with a 1 in the MSB and zeros elsewhere sets `nar_o`, clears `zero_o`, and drives `exp_o`, `mant_o` and `log_o` to 0.
- R9: With `EMIT_LOG` = 1, `log_o` (N+4 bits, two's complement, N-5 fraction bits) equals c + f for sign 0 and -(c + f) for sign 1. Here f is `mant_o` read as a binary fraction.
- R10: When N < 12, the codeword is treated as though zero bits were appended below its LSB. A characteristic longer than the available bits therefore reads those zeros, and the mantissa is all zero.
- R11: For codewords other than zero and Not-a-Real, `log_o` rises strictly as the codeword rises among sign-0 codes. It falls strictly as the codeword rises among sign-1 codes.
- R12: With `EMIT_LOG` = 0, `log_o` is 0 for every codeword.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| code_i | input | N | Codeword to decode |
| sign_o | output | 1 | Sign bit |
| exp_o | output | 9 | Signed exponent |
| mant_o | output | N-5 | Left-justified mantissa, zero filled |
| log_o | output | N+4 | Signed fixed-point logarithmic value (N-5 fraction bits) |
| zero_o | output | 1 | Codeword is zero |
| nar_o | output | 1 | Codeword is Not-a-Real |

## Verification
The decoder contains no register, so every output is valid in the same cycle that the codeword is applied. The delay between stimulus and result is zero cycles. The driver changes the codeword on the falling clock edge and pushes the reference result at the same time. The monitor compares on the next rising edge, half a period later, when the combinational outputs have settled. Every code is covered at N = 8 and N = 16, and the monotonic order of the log value is tracked across both sweeps. At N = 32 and N = 64, boundary codes and random codes are checked.

// File: rtl/tpdec_pkg.sv
package tpdec_pkg;

    localparam int HDR_W    = 5;   // sign + direction + run pattern
    localparam int PAT_W    = 3;
    localparam int RUN_MAX  = 7;
    localparam int EXP_W    = 9;   // exponent range -255..254
    localparam int HDR_MAXW = HDR_W + RUN_MAX;

    typedef logic [PAT_W-1:0]        run_t;
    typedef logic signed [EXP_W-1:0] exp_t;

    typedef struct packed {
        logic sign;
        logic dir;
        run_t run;
    } hdr_t;

    typedef enum logic [1:0] {
        CLS_NORMAL = 2'd0,
        CLS_ZERO   = 2'd1,
        CLS_NAR    = 2'd2
    } cls_t;

    // run length from direction bit and 3-bit pattern
    function automatic run_t run_from_pattern(logic dir, logic [PAT_W-1:0] pat);
        return dir ? pat : run_t'(RUN_MAX) - pat;
    endfunction

endpackage

// File: rtl/tpdec_header.sv
module tpdec_header
    import tpdec_pkg::*;
#(
    parameter int N = 16
) (
    input  logic [N-1:0]       code_i,
    output hdr_t               hdr_o,
    output logic [RUN_MAX-1:0] win_o,
    output logic [N-6:0]       body_o
);
    localparam int BODY_W = N - HDR_W;

    always_comb begin
        hdr_o.sign = code_i[N-1];
        hdr_o.dir  = code_i[N-2];
        hdr_o.run  = run_from_pattern(code_i[N-2], code_i[N-3 -: PAT_W]);
    end

    assign body_o = code_i[BODY_W-1:0];

    // window of at most seven bits that can hold the characteristic
    generate
        if (BODY_W >= RUN_MAX) begin : g_wide
            assign win_o = body_o[BODY_W-1 -: RUN_MAX];
        end else begin : g_short
            assign win_o = {body_o, {(RUN_MAX-BODY_W){1'b0}}};
        end
    endgenerate

endmodule

// File: rtl/tpdec_split.sv
module tpdec_split
    import tpdec_pkg::*;
#(
    parameter int N = 16
) (
    input  run_t               run_i,
    input  logic [RUN_MAX-1:0] win_i,
    input  logic [N-6:0]       body_i,
    output logic [RUN_MAX-1:0] raw_o,
    output logic [N-6:0]       mant_o
);
    localparam int BODY_W = N - HDR_W;

    always_comb begin
        raw_o  = win_i >> (run_t'(RUN_MAX) - run_i);
        mant_o = body_i << run_i;
    end

    always_comb begin
        if (int'(run_i) < BODY_W) begin
            assert_mant_align_R6: assert (mant_o[BODY_W-1] == body_i[BODY_W-1-int'(run_i)])
                else $error("mantissa MSB misaligned");
        end
    end

endmodule

// File: rtl/tpdec_char.sv
module tpdec_char
    import tpdec_pkg::*;
(
    input  logic               dir_i,
    input  run_t               run_i,
    input  logic [RUN_MAX-1:0] raw_i,
    output exp_t               char_o
);
    logic [EXP_W-1:0] lo_span;
    logic [EXP_W-1:0] hi_span;
    logic [EXP_W-1:0] raw_ext;

    always_comb begin
        lo_span = EXP_W'(1) << run_i;
        hi_span = EXP_W'(1) << ({1'b0, run_i} + 4'd1);
        raw_ext = {{(EXP_W-RUN_MAX){1'b0}}, raw_i};
        if (dir_i)
            char_o = exp_t'(lo_span - EXP_W'(1) + raw_ext);
        else
            char_o = exp_t'(raw_ext + EXP_W'(1) - hi_span);
    end

    always_comb begin
        if (dir_i) begin
            assert_char_pos_R3: assert (!char_o[EXP_W-1])
                else $error("upward characteristic negative");
        end else begin
            assert_char_neg_R4: assert (char_o[EXP_W-1])
                else $error("downward characteristic not negative");
        end
    end

endmodule

// File: rtl/tapered_decoder.sv
module tapered_decoder
    import tpdec_pkg::*;
#(
    parameter int N        = 16,
    parameter bit EMIT_LOG = 1'b1
) (
    input  logic [N-1:0]         code_i,
    output logic                 sign_o,
    output logic signed [8:0]    exp_o,
    output logic [N-6:0]         mant_o,
    output logic signed [N+3:0]  log_o,
    output logic                 zero_o,
    output logic                 nar_o
);
    localparam int BODY_W = N - HDR_W;
    localparam int LOG_W  = EXP_W + BODY_W;

    hdr_t               hdr;
    logic [RUN_MAX-1:0] win;
    logic [BODY_W-1:0]  body;
    logic [RUN_MAX-1:0] raw_char;
    logic [BODY_W-1:0]  mant_raw;
    exp_t               charac;
    cls_t               cls;
    logic               special;

    tpdec_header #(.N(N)) u_header (
        .code_i (code_i),
        .hdr_o  (hdr),
        .win_o  (win),
        .body_o (body)
    );

    tpdec_split #(.N(N)) u_split (
        .run_i  (hdr.run),
        .win_i  (win),
        .body_i (body),
        .raw_o  (raw_char),
        .mant_o (mant_raw)
    );

    tpdec_char u_char (
        .dir_i  (hdr.dir),
        .run_i  (hdr.run),
        .raw_i  (raw_char),
        .char_o (charac)
    );

    // flagging of the two reserved codewords
    always_comb begin
        if (code_i == '0)
            cls = CLS_ZERO;
        else if (code_i == {1'b1, {(N-1){1'b0}}})
            cls = CLS_NAR;
        else
            cls = CLS_NORMAL;
    end

    assign special = (cls != CLS_NORMAL);
    assign zero_o  = (cls == CLS_ZERO);
    assign nar_o   = (cls == CLS_NAR);
    assign sign_o  = hdr.sign;

    // exponent: sign-dependent conditional complement of the characteristic
    always_comb begin
        if (special)
            exp_o = '0;
        else if (hdr.sign)
            exp_o = ~charac;
        else
            exp_o = charac;
        mant_o = special ? '0 : mant_raw;
    end

    generate
        if (EMIT_LOG) begin : g_log
            logic signed [LOG_W-1:0] fix;
            assign fix = {charac, mant_raw};
            always_comb begin
                if (special)
                    log_o = '0;
                else if (hdr.sign)
                    log_o = -fix;
                else
                    log_o = fix;
            end
        end else begin : g_nolog
            assign log_o = '0;
        end
    endgenerate

    always_comb begin
        assert_flags_exclusive_R7: assert ($onehot0({zero_o, nar_o}))
            else $error("zero and NaR both set");
        assert_sign_bit_R1: assert (sign_o == code_i[N-1])
            else $error("sign mismatch");
        if (nar_o) begin
            assert_nar_quiet_R8: assert (exp_o == '0 && mant_o == '0 && log_o == '0)
                else $error("NaR outputs not cleared");
        end
        if (!zero_o && !nar_o) begin
            assert_exp_sign_R5: assert (exp_o[EXP_W-1] == (sign_o == hdr.dir))
                else $error("exponent sign inconsistent");
        end
    end

endmodule

// File: tb/tapered_decoder_tb.sv
`timescale 1ns/1ps
module tapered_decoder_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    typedef struct {
        int                 wid;
        logic [63:0]        code;
        logic               sgn;
        logic               dir;
        logic               zr;
        logic               nr;
        int                 ex;
        logic [71:0]        mant;
        logic signed [71:0] lg;
        bit                 mono_start;
        bit                 mono;
    } item_t;

    item_t q[$];
    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [7:0]  code8  = '0;
    logic [15:0] code16 = '0;
    logic [31:0] code32 = '0;
    logic [63:0] code64 = '0;

    logic sg8, z8, nr8, sg16, z16, nr16, sg32, z32, nr32, sg64, z64, nr64;
    logic signed [8:0] ex8, ex16, ex32, ex64;
    logic [2:0]  mt8;  logic [10:0] mt16; logic [26:0] mt32; logic [58:0] mt64;
    logic signed [11:0] lg8;  logic signed [19:0] lg16;
    logic signed [35:0] lg32; logic signed [67:0] lg64;
    logic sgx, zx, nrx; logic signed [8:0] exx; logic [2:0] mtx; logic signed [11:0] lgx;

    tapered_decoder #(.N(16)) u_dut (.code_i(code16), .sign_o(sg16), .exp_o(ex16), .mant_o(mt16),
        .log_o(lg16), .zero_o(z16), .nar_o(nr16));
    tapered_decoder #(.N(8)) u_dut8 (.code_i(code8), .sign_o(sg8), .exp_o(ex8), .mant_o(mt8),
        .log_o(lg8), .zero_o(z8), .nar_o(nr8));
    tapered_decoder #(.N(32)) u_dut32 (.code_i(code32), .sign_o(sg32), .exp_o(ex32), .mant_o(mt32),
        .log_o(lg32), .zero_o(z32), .nar_o(nr32));
    tapered_decoder #(.N(64)) u_dut64 (.code_i(code64), .sign_o(sg64), .exp_o(ex64), .mant_o(mt64),
        .log_o(lg64), .zero_o(z64), .nar_o(nr64));
    tapered_decoder #(.N(8), .EMIT_LOG(1'b0)) u_nolog8 (.code_i(code8), .sign_o(sgx), .exp_o(exx),
        .mant_o(mtx), .log_o(lgx), .zero_o(zx), .nar_o(nrx));

    function automatic logic bitk(logic [63:0] w, int n, int k);
        if (k < n) return w[n-1-k];
        return 1'b0;
    endfunction

    function automatic item_t ref_model(int n, logic [63:0] w);
        item_t it;
        int f, pat, rr, ci, cval;
        logic signed [71:0] cc;
        it.wid = n; it.code = w; f = n - 5;
        it.sgn = w[n-1];
        it.dir = w[n-2];
        it.zr  = (w == 64'd0);
        it.nr  = (w == (64'd1 << (n-1)));
        pat = int'((w >> (n-5)) & 64'd7);
        rr  = it.dir ? pat : 7 - pat;
        ci = 0;
        for (int j = 0; j < rr; j++) ci = ci * 2 + int'(bitk(w, n, 5 + j));
        cval = it.dir ? (1 << rr) - 1 + ci : ci + 1 - (1 << (rr + 1));
        it.mant = '0;
        for (int j = 0; j < f; j++) it.mant[f-1-j] = bitk(w, n, 5 + rr + j);
        it.mono_start = 1'b0; it.mono = 1'b0;
        if (it.zr || it.nr) begin
            it.ex = 0; it.mant = '0; it.lg = '0;
        end else begin
            it.ex = it.sgn ? -(cval + 1) : cval;
            cc = cval;
            it.lg = (cc <<< f) + $signed(it.mant);
            if (it.sgn) it.lg = -it.lg;
        end
        return it;
    endfunction

    task automatic chk(bit ok, string tag, string what, logic [71:0] act, logic [71:0] expv, logic [63:0] code);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s code=%0h actual=%0h expected=%0h", tag, what, code, act, expv);
        end
    endtask

    // driver: applies stimulus on the falling edge and pushes the expectation
    task automatic send(int n, logic [63:0] w, bit ms, bit mo);
        item_t it;
        logic [63:0] wm;
        wm = (n == 64) ? w : (w & ((64'd1 << n) - 64'd1));
        it = ref_model(n, wm);
        it.mono_start = ms; it.mono = mo;
        @(negedge clk);
        case (n)
            8:  code8  = wm[7:0];
            16: code16 = wm[15:0];
            32: code32 = wm[31:0];
            default: code64 = wm;
        endcase
        q.push_back(it);
    endtask

    // monitor: compares half a period after the codeword changed
    logic signed [71:0] prev_lg;
    bit prev_ok = 1'b0;
    always @(posedge clk) begin
        if (!rst && q.size() > 0) begin
            item_t it;
            logic s, z, nrv;
            int ex;
            logic [71:0] mt;
            logic signed [71:0] lg;
            string etag;
            it = q.pop_front();
            case (it.wid)
                8:  begin s = sg8;  z = z8;  nrv = nr8;  ex = ex8;  mt = 72'(mt8);  lg = lg8;  end
                16: begin s = sg16; z = z16; nrv = nr16; ex = ex16; mt = 72'(mt16); lg = lg16; end
                32: begin s = sg32; z = z32; nrv = nr32; ex = ex32; mt = 72'(mt32); lg = lg32; end
                default: begin s = sg64; z = z64; nrv = nr64; ex = ex64; mt = 72'(mt64); lg = lg64; end
            endcase
            if (it.zr) etag = "R7";
            else if (it.nr) etag = "R8";
            else if (it.sgn) etag = "R5";
            else if (it.dir) etag = "R3";
            else etag = "R4";
            chk(s == it.sgn, "R1", "sign", 72'(s), 72'(it.sgn), it.code);
            chk(z == it.zr, "R7", "zero flag", 72'(z), 72'(it.zr), it.code);
            chk(nrv == it.nr, "R8", "nar flag", 72'(nrv), 72'(it.nr), it.code);
            chk(ex == it.ex, {etag, " R2"}, "exponent", 72'(ex), 72'(it.ex), it.code);
            chk(mt == it.mant, (it.wid == 8) ? "R10" : "R6", "mantissa", mt, it.mant, it.code);
            chk(lg == it.lg, "R9", "log value", lg, it.lg, it.code);
            if (it.wid == 8)
                chk(lgx == '0, "R12", "log disabled", 72'(lgx), 72'd0, it.code);
            if (it.mono) begin
                if (!it.mono_start && prev_ok)
                    chk(it.sgn ? (lg < prev_lg) : (lg > prev_lg), "R11", "log order",
                        lg, prev_lg, it.code);
                prev_lg = lg;
                prev_ok = 1'b1;
            end
        end
    end

    task automatic corners(int n);
        logic [63:0] top;
        top = 64'd1 << (n - 1);
        send(n, 64'd0, 0, 0);                 // zero R7
        send(n, top, 0, 0);                   // NaR R8
        send(n, 64'd1, 0, 0);                 // smallest positive, deepest downward run
        send(n, top - 64'd1, 0, 0);           // largest positive
        send(n, top + 64'd1, 0, 0);           // most negative
        send(n, {64{1'b1}}, 0, 0);            // negative closest to zero
        send(n, top >> 1, 0, 0);              // unity: r = 0
        send(n, (top >> 1) - 64'd1, 0, 0);    // just below unity
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        foreach (q[i]) ;
        corners(8); corners(16); corners(32); corners(64);
        for (int v = 0; v < 256; v++)
            send(8, 64'(v), (v == 1) || (v == 129), (v != 0) && (v != 128));
        for (int v = 0; v < 65536; v++)
            send(16, 64'(v), (v == 1) || (v == 32769), (v != 0) && (v != 32768));
        for (int i = 0; i < 3000; i++) begin
            send(32, {32'd0, $urandom()}, 0, 0);
            send(64, {$urandom(), $urandom()}, 0, 0);
        end
        while (q.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog run did not complete actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule